// File: doc/BRIEF.md
# Accelerator Bus Decoder with Control and Status Registers

This block sits between a 64-bit external host bus carrying a 21-bit address and the on-chip storage of a convolution accelerator. Each bus request is classified by a three-bit region code in the top of the address. The block then raises exactly one write or read enable, for one of the image memories, one of the weight memories in a bank, one of the output memories, the control register or the status register. The low address bits go out as a shared local word address. Only the lower 48 bits of write data, three 16-bit values, go to the memories.

A write to the control register loads the layer configuration fields and can issue a one-cycle start command or a one-cycle finish command to the sequencer. A two-bit status register tracks busy and done. Output-memory and status reads return on the bus one cycle after the request, zero-extended to 64 bits.

Top module: `accel_bus_decode`

## Requirements
- R1: While a request is present, `mem_addr_o` equals address bits [10:0] and `mem_wdata_o` equals write-data bits [47:0].
- R2: A write with region code bits [20:18] = 3'b001 raises only `img_we_o[k]`, where k is address bits [13:11].
- R3: A write with region code 3'b010 raises only `wgt_we_o[8*b+m]`, where b is address bits [17:14] (bank 0..15) and m is bits [13:11] (memory 0..7).
- R4: A read with region code 3'b011 and bits [13:11] in 0..3 raises only `out_re_o[code]`, and the next cycle returns that memory's 48-bit word zero-extended. Codes 4..7 raise no enable and return zero.
- R5: Every read request gives `bus_rvalid_o` high for exactly the following cycle. A cycle with no read request gives `bus_rvalid_o` low in the next cycle.
- R6: A write with region code 3'b100 loads first-layer mode from bit 1, layer group from [3:2], iteration number from [5:4] and features per memory from [10:6]. These values hold until the next such write.
- R7: In that write, bit 0 produces `start_o` and bit 11 produces `finish_o`. Each is high for exactly the one cycle after the write.
- R8: A read with region code 3'b101 returns busy in bit 0 and done in bit 1, with zeros above. Start sets busy and clears done. `conv_done_i` clears busy and sets done.
- R9: Region codes 000, 110 and 111 raise no enable and change no register, and reads from them return zero. A request whose direction does not match its region does the same.
- R10: At most one memory enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Request valid for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 21 | Region, bank, memory and word address |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| conv_done_i | input | 1 | Convolution-finished pulse from the sequencer |
| img_we_o | output | 8 | Image memory write enables |
| wgt_we_o | output | 128 | Weight memory write enables, bank-major |
| out_re_o | output | 4 | Output memory read enables |
| mem_addr_o | output | 11 | Local word address to all memories |
| mem_wdata_o | output | 48 | Write word to all memories |
| out_rdata_i | input | 192 | Output memory read words, memory k at [48k+47:48k] |
| start_o | output | 1 | One-cycle start command |
| finish_o | output | 1 | One-cycle finish command |
| cfg_first_o | output | 1 | First-layer special mode |
| cfg_group_o | output | 2 | Layer group |
| cfg_iter_o | output | 2 | Iteration number |
| cfg_fpm_o | output | 5 | Features per memory |

## Verification
Random traffic covers all eight region codes, both directions, every bank and memory field and random data words. This separates correct steering from steering that is merely one-hot but points at the wrong index. Directed cases cover the corner weight indices 0 and 127, output code 4 and direction mismatches, which expose decode that ignores the region boundaries. Start, finish and done pulses are interleaved with status reads, so a busy/done priority error or a sticky command bit shows up as a wrong status word or a second pulse cycle.

// File: rtl/accel_bus_pkg.sv
package accel_bus_pkg;
  typedef enum logic [2:0] {
    RG_NONE    = 3'd0,
    RG_IMG_WR  = 3'd1,
    RG_WGT_WR  = 3'd2,
    RG_OUT_RD  = 3'd3,
    RG_CTRL_WR = 3'd4,
    RG_STAT_RD = 3'd5
  } region_e;

  localparam int REGION_W = 3;

  // control word bit positions
  localparam int CW_START  = 0;
  localparam int CW_FIRST  = 1;
  localparam int CW_GROUP  = 2;
  localparam int CW_ITER   = 4;
  localparam int CW_FPM    = 6;
  localparam int CW_FINISH = 11;
  localparam int CW_W      = 12;

  typedef struct packed {
    logic       first_layer;
    logic [1:0] group;
    logic [1:0] iter;
    logic [4:0] fpm;
  } cfg_t;

  localparam int STAT_W = 2;
endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode
  import accel_bus_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int LADDR_W = 11,
  parameter int N_BANK  = 16,
  parameter int N_MEM   = 8,
  parameter int N_OUT   = 4
) (
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [N_MEM-1:0]        img_we_o,
  output logic [N_BANK*N_MEM-1:0] wgt_we_o,
  output logic [N_OUT-1:0]        out_re_o,
  output logic                    ctrl_wr_o,
  output logic                    stat_rd_o
);
  localparam int MEM_W  = $clog2(N_MEM);
  localparam int BANK_W = $clog2(N_BANK);

  logic [MEM_W-1:0]  mem_sel;
  logic [BANK_W-1:0] bank_sel;
  region_e           region;
  logic hit_img, hit_wgt, hit_out;

  assign mem_sel  = addr_i[LADDR_W +: MEM_W];
  assign bank_sel = addr_i[LADDR_W+MEM_W +: BANK_W];
  assign region   = region_e'(addr_i[ADDR_W-1 -: REGION_W]);

  assign hit_img   = req_i &&  we_i && (region == RG_IMG_WR);
  assign hit_wgt   = req_i &&  we_i && (region == RG_WGT_WR);
  assign hit_out   = req_i && !we_i && (region == RG_OUT_RD);
  assign ctrl_wr_o = req_i &&  we_i && (region == RG_CTRL_WR);
  assign stat_rd_o = req_i && !we_i && (region == RG_STAT_RD);

  for (genvar m = 0; m < N_MEM; m++) begin : g_img
    assign img_we_o[m] = hit_img && (mem_sel == MEM_W'(m));
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
      assign wgt_we_o[b*N_MEM+m] = hit_wgt && (bank_sel == BANK_W'(b))
                                   && (mem_sel == MEM_W'(m));
    end
  end

  // codes at or above N_OUT select nothing
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign out_re_o[o] = hit_out && (mem_sel == MEM_W'(o));
  end
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import accel_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CW_W-1:0]   wdata_i,
  input  logic              conv_done_i,
  output cfg_t              cfg_o,
  output logic              start_o,
  output logic              finish_o,
  output logic [STAT_W-1:0] status_o
);
  logic start_cmd;
  logic busy_q, done_q;

  assign start_cmd = wr_i && wdata_i[CW_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      start_o  <= 1'b0;
      finish_o <= 1'b0;
    end else begin
      start_o  <= start_cmd;
      finish_o <= wr_i && wdata_i[CW_FINISH];
      if (wr_i) begin
        cfg_o.first_layer <= wdata_i[CW_FIRST];
        cfg_o.group       <= wdata_i[CW_GROUP +: 2];
        cfg_o.iter        <= wdata_i[CW_ITER +: 2];
        cfg_o.fpm         <= wdata_i[CW_FPM +: 5];
      end
    end
  end

  // start wins over a coincident done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_cmd) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (conv_done_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign status_o = {done_q, busy_q};
endmodule

// File: rtl/read_return.sv
module read_return
  import accel_bus_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int WORD_W = 48,
  parameter int DATA_W = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [N_OUT-1:0]        out_re_i,
  input  logic                    stat_rd_i,
  input  logic [STAT_W-1:0]       status_i,
  input  logic [N_OUT*WORD_W-1:0] out_rdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o
);
  logic [N_OUT-1:0]  sel_q;
  logic [STAT_W-1:0] stat_q;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      sel_q    <= '0;
      stat_q   <= '0;
    end else begin
      rvalid_o <= rd_i;
      sel_q    <= out_re_i;
      stat_q   <= stat_rd_i ? status_i : '0;
    end
  end

  always_comb begin
    word = '0;
    for (int o = 0; o < N_OUT; o++) begin
      if (sel_q[o]) word = word | out_rdata_i[o*WORD_W +: WORD_W];
    end
  end

  assign rdata_o = DATA_W'(word) | DATA_W'(stat_q);
endmodule

// File: rtl/accel_bus_decode.sv
module accel_bus_decode
  import accel_bus_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 64,
  parameter int LADDR_W = 11,
  parameter int WORD_W  = 48,
  parameter int N_BANK  = 16,
  parameter int N_MEM   = 8,
  parameter int N_OUT   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_req_i,
  input  logic                    bus_we_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    bus_rvalid_o,
  input  logic                    conv_done_i,
  output logic [N_MEM-1:0]        img_we_o,
  output logic [N_BANK*N_MEM-1:0] wgt_we_o,
  output logic [N_OUT-1:0]        out_re_o,
  output logic [LADDR_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o,
  input  logic [N_OUT*WORD_W-1:0] out_rdata_i,
  output logic                    start_o,
  output logic                    finish_o,
  output logic                    cfg_first_o,
  output logic [1:0]              cfg_group_o,
  output logic [1:0]              cfg_iter_o,
  output logic [4:0]              cfg_fpm_o
);
  logic              ctrl_wr, stat_rd;
  logic [STAT_W-1:0] status;
  cfg_t              cfg;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:WORD_W];
  assign mem_addr_o   = bus_addr_i[LADDR_W-1:0];
  assign mem_wdata_o  = bus_wdata_i[WORD_W-1:0];

  bus_region_decode #(
    .ADDR_W(ADDR_W), .LADDR_W(LADDR_W), .N_BANK(N_BANK), .N_MEM(N_MEM), .N_OUT(N_OUT)
  ) u_dec (
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .img_we_o(img_we_o), .wgt_we_o(wgt_we_o), .out_re_o(out_re_o),
    .ctrl_wr_o(ctrl_wr), .stat_rd_o(stat_rd)
  );

  ctrl_regs u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ctrl_wr),
    .wdata_i(bus_wdata_i[CW_W-1:0]), .conv_done_i(conv_done_i),
    .cfg_o(cfg), .start_o(start_o), .finish_o(finish_o), .status_o(status)
  );

  read_return #(.N_OUT(N_OUT), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(bus_req_i && !bus_we_i),
    .out_re_i(out_re_o), .stat_rd_i(stat_rd), .status_i(status),
    .out_rdata_i(out_rdata_i), .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  assign cfg_first_o = cfg.first_layer;
  assign cfg_group_o = cfg.group;
  assign cfg_iter_o  = cfg.iter;
  assign cfg_fpm_o   = cfg.fpm;
endmodule

// File: rtl/accel_bus_decode_chk.sv
module accel_bus_decode_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_req_i,
  input logic         bus_we_i,
  input logic [20:0]  bus_addr_i,
  input logic [63:0]  bus_rdata_o,
  input logic         bus_rvalid_o,
  input logic [7:0]   img_we_o,
  input logic [127:0] wgt_we_o,
  input logic [3:0]   out_re_o,
  input logic         start_o,
  input logic         finish_o
);
  logic unmapped;
  assign unmapped = (bus_addr_i[20:18] == 3'd0) || (bus_addr_i[20:18] >= 3'd6);

  // R10
  onehot_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({img_we_o, wgt_we_o, out_re_o}));

  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R7
  finish_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !finish_o);

  // R5
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o);

  // R5
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o);

  // R9
  unmapped_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && unmapped) |-> ({img_we_o, wgt_we_o, out_re_o} == '0));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && unmapped) |=> (bus_rdata_o == 64'd0));
endmodule

bind accel_bus_decode accel_bus_decode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
  .img_we_o(img_we_o), .wgt_we_o(wgt_we_o), .out_re_o(out_re_o),
  .start_o(start_o), .finish_o(finish_o)
);

// File: tb/sim_accel_bus_decode.sv
`timescale 1ns/1ps
module sim_accel_bus_decode;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bus_req_i = 1'b0;
  logic         bus_we_i = 1'b0;
  logic [20:0]  bus_addr_i = '0;
  logic [63:0]  bus_wdata_i = '0;
  logic [63:0]  bus_rdata_o;
  logic         bus_rvalid_o;
  logic         conv_done_i = 1'b0;
  logic [7:0]   img_we_o;
  logic [127:0] wgt_we_o;
  logic [3:0]   out_re_o;
  logic [10:0]  mem_addr_o;
  logic [47:0]  mem_wdata_o;
  logic [191:0] out_rdata_i = '0;
  logic         start_o, finish_o, cfg_first_o;
  logic [1:0]   cfg_group_o, cfg_iter_o;
  logic [4:0]   cfg_fpm_o;

  int total = 0;
  int bad = 0;

  // bench model
  logic       m_first = 0, m_busy = 0, m_done = 0;
  logic [1:0] m_group = 0, m_iter = 0;
  logic [4:0] m_fpm = 0;

  always #2.5 clk_i = ~clk_i;

  accel_bus_decode u0 (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_img(logic we, logic [20:0] a);
    return (we && a[20:18] == 3'd1) ? (8'd1 << a[13:11]) : 8'd0;
  endfunction

  function automatic logic [127:0] f_wgt(logic we, logic [20:0] a);
    return (we && a[20:18] == 3'd2) ? (128'd1 << (a[17:14] * 8 + a[13:11])) : 128'd0;
  endfunction

  function automatic logic [3:0] f_out(logic we, logic [20:0] a);
    return (!we && a[20:18] == 3'd3 && a[13:11] < 3'd4) ? (4'd1 << a[13:11]) : 4'd0;
  endfunction

  function automatic logic [63:0] f_rd(logic [20:0] a);
    if (a[20:18] == 3'd3 && a[13:11] < 3'd4) return {16'd0, out_rdata_i[a[12:11]*48 +: 48]};
    if (a[20:18] == 3'd5) return {62'd0, m_done, m_busy};
    return 64'd0;
  endfunction

  task automatic txn(input logic [20:0] a, input logic we, input logic [63:0] d);
    logic        is_ctrl;
    logic [63:0] exp_rd;
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    #1;
    check("R2 img_we", 128'(img_we_o), 128'(f_img(we, a)));
    check("R3 wgt_we", wgt_we_o, f_wgt(we, a));
    check("R4 out_re", 128'(out_re_o), 128'(f_out(we, a)));
    check("R1 addr", 128'(mem_addr_o), 128'(a[10:0]));
    check("R1 wdata", 128'(mem_wdata_o), 128'(d[47:0]));
    is_ctrl = we && a[20:18] == 3'd4;
    exp_rd  = f_rd(a);
    if (is_ctrl) begin
      m_first = d[1]; m_group = d[3:2]; m_iter = d[5:4]; m_fpm = d[10:6];
      if (d[0]) begin m_busy = 1'b1; m_done = 1'b0; end
    end
    @(negedge clk_i);
    bus_req_i = 1'b0;
    check("R5 rvalid", 128'(bus_rvalid_o), 128'(!we));
    if (!we) check("R4 R8 R9 rdata", 128'(bus_rdata_o), 128'(exp_rd));
    check("R7 start", 128'(start_o), 128'(is_ctrl && d[0]));
    check("R7 finish", 128'(finish_o), 128'(is_ctrl && d[11]));
    check("R6 cfg", 128'({cfg_first_o, cfg_group_o, cfg_iter_o, cfg_fpm_o}),
          128'({m_first, m_group, m_iter, m_fpm}));
    @(negedge clk_i);
    check("R7 start drop", 128'({start_o, finish_o}), 128'd0);
    check("R5 rvalid drop", 128'(bus_rvalid_o), 128'd0);
  endtask

  task automatic done_pulse();
    @(negedge clk_i);
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    if (!m_busy || 1'b1) begin m_busy = 1'b0; m_done = 1'b1; end
  endtask

  function automatic logic [20:0] mk(logic [2:0] rg, logic [3:0] bk, logic [2:0] mm, logic [10:0] w);
    return {rg, bk, mm, w};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) out_rdata_i[k*48 +: 48] = {$urandom, $urandom};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    check("R5 reset rvalid", 128'(bus_rvalid_o), 128'd0);
    check("R8 reset rdata", 128'(bus_rdata_o), 128'd0);
    check("R10 reset enables", {img_we_o, out_re_o} | wgt_we_o, 128'd0);
    check("R6 reset cfg", 128'({cfg_first_o, cfg_group_o, cfg_iter_o, cfg_fpm_o}), 128'd0);

    // directed corners
    txn(mk(3'd2, 4'd0, 3'd0, 11'h001), 1'b1, 64'hFFFF_1234_5678_9ABC);
    txn(mk(3'd2, 4'd15, 3'd7, 11'h7FF), 1'b1, 64'h0);
    txn(mk(3'd1, 4'd9, 3'd5, 11'h123), 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
    txn(mk(3'd3, 4'd0, 3'd3, 11'h0), 1'b0, 64'h0);
    txn(mk(3'd3, 4'd0, 3'd4, 11'h0), 1'b0, 64'h0);   // R4 code 4 -> zero
    txn(mk(3'd3, 4'd0, 3'd1, 11'h0), 1'b1, 64'h5);   // R9 wrong direction
    txn(mk(3'd1, 4'd0, 3'd1, 11'h0), 1'b0, 64'h0);   // R9 wrong direction
    txn(mk(3'd6, 4'd2, 3'd2, 11'h0), 1'b1, 64'hFFF); // R9 unmapped write
    txn(mk(3'd7, 4'd2, 3'd2, 11'h0), 1'b0, 64'h0);   // R9 unmapped read
    txn(mk(3'd5, 4'd0, 3'd0, 11'h0), 1'b0, 64'h0);   // R8 idle status
    txn(mk(3'd4, 4'd0, 3'd0, 11'h0), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF); // start+finish
    txn(mk(3'd5, 4'd0, 3'd0, 11'h0), 1'b0, 64'h0);   // R8 busy
    txn(mk(3'd5, 4'd0, 3'd0, 11'h0), 1'b1, 64'h3);   // R9 write to status
    done_pulse();
    txn(mk(3'd5, 4'd0, 3'd0, 11'h0), 1'b0, 64'h0);   // R8 done
    txn(mk(3'd4, 4'd0, 3'd0, 11'h0), 1'b1, 64'h0000_0000_0000_0556); // R6 no start
    txn(mk(3'd5, 4'd0, 3'd0, 11'h0), 1'b0, 64'h0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [20:0] a;
      logic        we;
      logic [63:0] d;
      a  = 21'($urandom);
      d  = {$urandom, $urandom};
      we = 1'($urandom);
      if ($urandom_range(0, 9) < 7) begin
        case (a[20:18])
          3'd1, 3'd2, 3'd4: we = 1'b1;
          3'd3, 3'd5:       we = 1'b0;
          default: ;
        endcase
      end
      if (a[20:18] == 3'd4 && $urandom_range(0, 3) != 0) d[11] = 1'b0;
      txn(a, we, d);
      if ($urandom_range(0, 15) == 0) done_pulse();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule